// File: doc/BRIEF.md
# Direction-Based Static Branch Predictor with Wrong-Path Squash

This block chooses the next fetch address for a pipelined core and cleans up after a wrong guess. It holds the fetch PC. Each cycle the decoder reports whether the fetched word is a branch and gives its signed byte offset. A branch that jumps backward, which is typical of a loop, is guessed taken, and fetch moves to the branch target. Every other word, including a branch that jumps forward, lets fetch run on sequentially at PC+4.

The guess bit is output alongside the fetched word. The pipeline carries it to the resolve stage, which later hands the bit back with the real outcome. If the two disagree, the block redirects fetch to the correct path. In the same cycle it clears the control fields of the younger in-flight instructions to zero, which turns them into no-ops before they can write the register file or memory. Two counters record the resolved branches and the wrong guesses, so a test environment can check prediction quality.

Top module: `bpred_fetch_ctl`

## Requirements
- R1: While reset is asserted, `fetch_pc` takes `RESET_PC` (default 0), both counters are zero and `flush` is low.
- R2: When `if_valid` is high and `if_is_br` is low, `if_pred_taken` is 0 and `fetch_pc` advances by 4 on the next clock edge.
- R3: When `if_valid` and `if_is_br` are high and bit 31 of `if_offset` is 1 (a negative offset), `if_pred_taken` is 1 and the next `fetch_pc` is `fetch_pc + if_offset`.
- R4: When a valid branch has bit 31 of `if_offset` at 0 (a zero or positive offset), `if_pred_taken` is 0 and the next `fetch_pc` is `fetch_pc + 4`.
- R5: When `if_valid` is low, `fetch_pc` holds its value and `if_pred_taken` is 0.
- R6: In the cycle when `rs_valid` is high and `rs_pred` differs from `rs_taken`, `flush` is high. If they agree, `flush` is low.
- R7: When a branch was guessed taken but resolves not taken, the next `fetch_pc` is `rs_pc + 4`.
- R8: When a branch was guessed not taken but resolves taken, the next `fetch_pc` is `rs_target`.
- R9: A redirect takes priority over a guess made at fetch in the same cycle.
- R10: While `flush` is high, every `CTRL_W`-bit slice of `yng_ctrl_o` is zero. Otherwise `yng_ctrl_o` equals `yng_ctrl_i`.
- R11: `br_count` increments once per cycle in which `rs_valid` is high. `mis_count` increments once per cycle in which `flush` is high.
- R12: When `rs_valid` is low, the values of `rs_pred`, `rs_taken`, `rs_pc` and `rs_target` have no effect: no flush occurs, the counters stay unchanged and the PC follows the fetch rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | The fetch stage holds a decoded word this cycle |
| if_is_br | input | 1 | The fetched word is a conditional branch |
| if_offset | input | 32 | Signed byte offset of the branch target |
| fetch_pc | output | 32 | Current fetch address |
| if_pred_taken | output | 1 | Guess bit to carry with the fetched branch |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pred | input | 1 | Guess bit that travelled with the resolving branch |
| rs_taken | input | 1 | Actual outcome of the resolving branch |
| rs_pc | input | 32 | Address of the resolving branch |
| rs_target | input | 32 | Target address of the resolving branch |
| flush | output | 1 | Wrong guess detected; younger work is squashed |
| yng_ctrl_i | input | 16 | Control fields of the younger stages, `STAGES` slices of `CTRL_W` bits |
| yng_ctrl_o | output | 16 | Control fields after squash |
| br_count | output | 32 | Number of resolved branches |
| mis_count | output | 32 | Number of wrong guesses |

## Verification
Resolution and prediction can occur in the same cycle: a wrong guess can surface while fetch is looking at a new branch whose own guess would also move the PC. The bench creates this overlap on purpose. In one case a backward branch is fetched while a taken-guess turns out not taken. In another a forward branch is fetched while a not-taken guess turns out taken. In both cases the next PC must be the recovery address and not the fresh guess, and in that same cycle the younger control fields must read zero.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  localparam int unsigned PC_W        = 32;
  localparam int unsigned INSTR_BYTES = 4;

  typedef logic [PC_W-1:0] pc_t;

  // backward (negative) offset on a branch => guess taken
  function automatic logic fn_guess(logic is_br, pc_t off);
    return is_br & off[PC_W-1];
  endfunction

  function automatic pc_t fn_seq(pc_t pc);
    return pc + pc_t'(INSTR_BYTES);
  endfunction

  function automatic pc_t fn_jump(pc_t pc, pc_t off);
    return pc + off;
  endfunction

  // address of the path the branch really follows
  function automatic pc_t fn_recover(logic taken, pc_t pc, pc_t tgt);
    return taken ? tgt : fn_seq(pc);
  endfunction
endpackage

// File: rtl/bp_dir_pred.sv
module bp_dir_pred
  import bpred_pkg::*;
(
  input  logic valid_i,
  input  logic is_br_i,
  input  pc_t  pc_i,
  input  pc_t  offset_i,
  output logic guess_o,
  output pc_t  npc_o
);
  logic guess_w;
  assign guess_w = valid_i & fn_guess(is_br_i, offset_i);
  assign guess_o = guess_w;
  assign npc_o   = guess_w ? fn_jump(pc_i, offset_i) : fn_seq(pc_i);
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve
  import bpred_pkg::*;
(
  input  logic valid_i,
  input  logic pred_i,
  input  logic taken_i,
  input  pc_t  pc_i,
  input  pc_t  target_i,
  output logic wrong_o,
  output pc_t  recover_o
);
  assign wrong_o   = valid_i & (pred_i ^ taken_i);
  assign recover_o = fn_recover(taken_i, pc_i, target_i);
endmodule

// File: rtl/bp_squash.sv
module bp_squash #(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic                       kill_i,
  input  logic [STAGES*CTRL_W-1:0]   ctrl_i,
  output logic [STAGES*CTRL_W-1:0]   ctrl_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign ctrl_o[s*CTRL_W +: CTRL_W] = kill_i ? '0 : ctrl_i[s*CTRL_W +: CTRL_W];
  end
endmodule

// File: rtl/bp_counters.sv
module bp_counters #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_ev_i,
  input  logic             mis_ev_i,
  output logic [CNT_W-1:0] br_cnt_o,
  output logic [CNT_W-1:0] mis_cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_cnt_o  <= '0;
      mis_cnt_o <= '0;
    end else begin
      if (br_ev_i)  br_cnt_o  <= br_cnt_o + 1'b1;
      if (mis_ev_i) mis_cnt_o <= mis_cnt_o + 1'b1;
    end
  end

  // R11
  mis_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mis_ev_i |=> mis_cnt_o == $past(mis_cnt_o) + 1'b1);
  // R12
  br_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_ev_i |=> $stable(br_cnt_o));
endmodule

// File: rtl/bpred_fetch_ctl.sv
module bpred_fetch_ctl
  import bpred_pkg::*;
#(
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned STAGES   = 2,
  parameter int unsigned CNT_W    = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     if_valid,
  input  logic                     if_is_br,
  input  logic [31:0]              if_offset,
  output logic [31:0]              fetch_pc,
  output logic                     if_pred_taken,
  input  logic                     rs_valid,
  input  logic                     rs_pred,
  input  logic                     rs_taken,
  input  logic [31:0]              rs_pc,
  input  logic [31:0]              rs_target,
  output logic                     flush,
  input  logic [STAGES*CTRL_W-1:0] yng_ctrl_i,
  output logic [STAGES*CTRL_W-1:0] yng_ctrl_o,
  output logic [CNT_W-1:0]         br_count,
  output logic [CNT_W-1:0]         mis_count
);
  localparam int unsigned CTRL_BITS = STAGES * CTRL_W;

  pc_t  pc_q;
  pc_t  guess_npc;
  pc_t  recover_pc;
  logic guess_tk;
  logic wrong_ev;      // internal event: resolve disagrees with guess
  logic take_redir;    // internal event: PC loads recovery address
  logic take_fetch;    // internal event: PC loads guessed address

  bp_dir_pred u_dir (
    .valid_i (if_valid),
    .is_br_i (if_is_br),
    .pc_i    (pc_q),
    .offset_i(if_offset),
    .guess_o (guess_tk),
    .npc_o   (guess_npc)
  );

  bp_resolve u_res (
    .valid_i  (rs_valid),
    .pred_i   (rs_pred),
    .taken_i  (rs_taken),
    .pc_i     (rs_pc),
    .target_i (rs_target),
    .wrong_o  (wrong_ev),
    .recover_o(recover_pc)
  );

  bp_squash #(.CTRL_W(CTRL_W), .STAGES(STAGES)) u_sq (
    .kill_i(wrong_ev),
    .ctrl_i(yng_ctrl_i),
    .ctrl_o(yng_ctrl_o)
  );

  bp_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_ev_i  (rs_valid),
    .mis_ev_i (wrong_ev),
    .br_cnt_o (br_count),
    .mis_cnt_o(mis_count)
  );

  assign take_redir = wrong_ev;
  assign take_fetch = if_valid & ~wrong_ev;

  always_ff @(posedge clk) begin
    if (!rst_n)          pc_q <= RESET_PC;
    else if (take_redir) pc_q <= recover_pc;
    else if (take_fetch) pc_q <= guess_npc;
  end

  assign fetch_pc      = pc_q;
  assign if_pred_taken = guess_tk;
  assign flush         = wrong_ev;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_valid && !if_is_br && !flush) |=> fetch_pc == $past(fetch_pc) + 32'd4);
  // R3
  back_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_valid && if_is_br && if_offset[31] && !flush) |=>
      fetch_pc == $past(fetch_pc) + $past(if_offset));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_valid && !flush) |=> $stable(fetch_pc));
  // R7
  undo_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_pred && !rs_taken) |=> fetch_pc == $past(rs_pc) + 32'd4);
  // R8
  late_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_pred && rs_taken) |=> fetch_pc == $past(rs_target));
  // R10
  squash_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> yng_ctrl_o == {CTRL_BITS{1'b0}});
  // R10
  squash_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> yng_ctrl_o == yng_ctrl_i);
  // R12
  rs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !flush);
endmodule

// File: tb/tb_bpred_fetch_ctl.sv
module tb_bpred_fetch_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_valid = 1'b0, if_is_br = 1'b0;
  logic [31:0] if_offset = '0;
  logic [31:0] fetch_pc;
  logic        if_pred_taken;
  logic        rs_valid = 1'b0, rs_pred = 1'b0, rs_taken = 1'b0;
  logic [31:0] rs_pc = '0, rs_target = '0;
  logic        flush;
  logic [15:0] yng_ctrl_i = 16'hA55A;
  logic [15:0] yng_ctrl_o;
  logic [31:0] br_count, mis_count;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_pc = '0, exp_br = '0, exp_mis = '0;

  always #10 clk = ~clk;

  bpred_fetch_ctl dut (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_is_br(if_is_br),
    .if_offset(if_offset), .fetch_pc(fetch_pc), .if_pred_taken(if_pred_taken),
    .rs_valid(rs_valid), .rs_pred(rs_pred), .rs_taken(rs_taken), .rs_pc(rs_pc),
    .rs_target(rs_target), .flush(flush), .yng_ctrl_i(yng_ctrl_i),
    .yng_ctrl_o(yng_ctrl_o), .br_count(br_count), .mis_count(mis_count)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock, then registered checks 5 ns after the edge
  task automatic tick_and_check(string req);
    @(posedge clk);
    #5;
    chk({req, " pc"}, fetch_pc, exp_pc);
    chk("R11 br_count", br_count, exp_br);
    chk("R11 mis_count", mis_count, exp_mis);
  endtask

  task automatic idle_inputs();
    if_valid = 0; if_is_br = 0; if_offset = '0;
    rs_valid = 0; rs_pred = 0; rs_taken = 0; rs_pc = '0; rs_target = '0;
  endtask

  task automatic t_reset();
    chk("R1 pc", fetch_pc, 32'h0);
    chk("R1 br", br_count, 32'h0);
    chk("R1 mis", mis_count, 32'h0);
    chk("R1 flush", {31'b0, flush}, 32'h0);
  endtask

  task automatic t_sequential();
    for (int i = 0; i < 3; i++) begin
      if_valid = 1; if_is_br = 0; if_offset = 32'hFFFF_FFF0;
      #1 chk("R2 guess", {31'b0, if_pred_taken}, 32'h0);
      exp_pc = exp_pc + 4;
      tick_and_check("R2");
    end
  endtask

  task automatic t_backward();
    if_valid = 1; if_is_br = 1; if_offset = -32'sd8;
    #1 chk("R3 guess", {31'b0, if_pred_taken}, 32'h1);
    exp_pc = exp_pc - 8;
    tick_and_check("R3");
  endtask

  task automatic t_forward();
    if_valid = 1; if_is_br = 1; if_offset = 32'd64;
    #1 chk("R4 guess", {31'b0, if_pred_taken}, 32'h0);
    exp_pc = exp_pc + 4;
    tick_and_check("R4");
    if_offset = 32'd0;
    #1 chk("R4 zero-off guess", {31'b0, if_pred_taken}, 32'h0);
    exp_pc = exp_pc + 4;
    tick_and_check("R4");
  endtask

  task automatic t_hold();
    if_valid = 0; if_is_br = 1; if_offset = -32'sd16;
    #1 chk("R5 guess", {31'b0, if_pred_taken}, 32'h0);
    tick_and_check("R5");
    tick_and_check("R5");
  endtask

  task automatic t_resolve_ok();
    idle_inputs();
    rs_valid = 1; rs_pred = 1; rs_taken = 1; rs_pc = 32'h40; rs_target = 32'h900;
    #1 chk("R6 agree flush", {31'b0, flush}, 32'h0);
    chk("R10 pass", {16'b0, yng_ctrl_o}, {16'b0, yng_ctrl_i});
    exp_br++;
    tick_and_check("R6");
  endtask

  task automatic t_undo_taken();
    // R9: backward branch fetched in the same cycle
    if_valid = 1; if_is_br = 1; if_offset = -32'sd32;
    rs_valid = 1; rs_pred = 1; rs_taken = 0; rs_pc = 32'h100; rs_target = 32'h80;
    yng_ctrl_i = 16'h3CC3;
    #1 chk("R6 flush", {31'b0, flush}, 32'h1);
    chk("R10 zeroed", {16'b0, yng_ctrl_o}, 32'h0);
    exp_pc = 32'h104; exp_br++; exp_mis++;
    tick_and_check("R7/R9");
  endtask

  task automatic t_late_taken();
    // R9: forward branch fetched in the same cycle
    if_valid = 1; if_is_br = 1; if_offset = 32'd12;
    rs_valid = 1; rs_pred = 0; rs_taken = 1; rs_pc = 32'h200; rs_target = 32'h2000;
    yng_ctrl_i = 16'hFFFF;
    #1 chk("R6 flush", {31'b0, flush}, 32'h1);
    chk("R10 zeroed", {16'b0, yng_ctrl_o}, 32'h0);
    exp_pc = 32'h2000; exp_br++; exp_mis++;
    tick_and_check("R8/R9");
  endtask

  task automatic t_rs_ignored();
    if_valid = 1; if_is_br = 0; if_offset = '0;
    rs_valid = 0; rs_pred = 1; rs_taken = 0; rs_pc = 32'h700; rs_target = 32'h800;
    yng_ctrl_i = 16'h1234;
    #1 chk("R12 no flush", {31'b0, flush}, 32'h0);
    chk("R10 pass", {16'b0, yng_ctrl_o}, 32'h1234);
    exp_pc = exp_pc + 4;
    tick_and_check("R12");
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    t_reset();
    rst_n = 1;
    t_sequential();
    t_backward();
    t_forward();
    t_hold();
    t_resolve_ok();
    t_undo_taken();
    t_late_taken();
    t_rs_ignored();
    idle_inputs();
    tick_and_check("R5 final");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule